// File: doc/BRIEF.md
# PRBS7 Pattern Generator and Error Checker

This block makes a pseudo-random test pattern of period 127 and measures how many bits of it arrive wrong. The generator is an 8-bit shift register with a single XOR in its feedback path, using the polynomial x^7 + x^6 + 1. Each enabled clock shifts the register by one place. The whole register is presented as a parallel word, and the newest bit is also presented as a serial output.

The checker is independent of the generator. It takes a serial stream with a per-bit valid qualifier and loads seven received bits. It then has to see sixteen correct predictions in a row, and after that it declares lock. Once locked, it runs on its own predictions. Every received bit that disagrees with the prediction gives a one-cycle error pulse and increments a saturating error counter. A second counter totals the bits that were checked. A sliding window drops lock when errors become dense, and the checker then resynchronises from scratch. In normal use the serial output, possibly passed through a link under test, is fed back into the checker input.

Top module: `prbs7_link`

## Requirements
- R1: While `rst` is high at a clock edge, the word loads the seed `SEED` (default 8'h81), the checker goes unlocked, `rx_err` goes to 0 and both counters go to 0. `gen_bit` always equals word bit 0.
- R2: On each edge with `gen_en` high, the word shifts toward its MSB by one place. The new bit 0 is the XOR of old bit 6 and old bit 5, which are feedback stages 7 and 6 when counted from 1.
- R3: On an edge with `gen_en` low, the word keeps its value.
- R4: From the default seed, the word returns to the seed after exactly 127 enabled steps, with no value repeated in between. The low seven bits are never all zero.
- R5: Starting from reset or from a loss of lock, `rx_locked` rises on the edge that samples the 23rd valid bit of a clean stream: seven bits to fill the history, then sixteen correct predictions. A wrong prediction during the sixteen restarts that run.
- R6: While locked, a valid bit that differs from the prediction raises `rx_err` for the one cycle after its sampling edge and adds one to `rx_err_count`. The locked history takes the predicted bit, so one flipped bit gives exactly one error.
- R7: `rx_bit_count` rises by one for each valid bit sampled while locked, and for no other bit.
- R8: Both counters stop at all-ones. An error sampled while `rx_err_count` is full still pulses `rx_err`.
- R9: When the bits checked while locked contain eight errors within any 64 consecutive bits, lock is dropped on the edge of the eighth error. Seven errors within 64 bits keep lock.
- R10: An edge with `rx_valid` low leaves the lock state and both counters unchanged and gives no error pulse, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Generator step enable |
| gen_word | output | 8 | Generator register contents |
| gen_bit | output | 1 | Newest generated bit (word bit 0) |
| rx_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Received serial bit |
| rx_locked | output | 1 | Checker is synchronised |
| rx_err | output | 1 | One-cycle pulse per detected bit error |
| rx_err_count | output | CNT_W (32) | Saturating count of detected errors |
| rx_bit_count | output | CNT_W (32) | Saturating count of bits checked while locked |

## Verification
The bench sends single isolated flips into a locked stream. A checker that fed received bits into its history would count three errors for each flip, not one. Error bursts of seven and of eight within a 64-bit span are placed either side of the drop threshold, which would expose an off-by-one in the window count or in its length. A flip placed during training checks that the run restarts, so a checker that locked on a broken stream would lock too early. With narrowed counters, both counters are driven into saturation, which would show any wrap-around. A full period is also walked to confirm that no state repeats and that the sequence closes exactly at 127 steps.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

   typedef enum logic [1:0] {
      SYNC_FILL  = 2'd0,
      SYNC_TRAIN = 2'd1,
      SYNC_LOCK  = 2'd2
   } sync_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/prbs_lfsr_gen.sv
module prbs_lfsr_gen #(
   parameter int unsigned     REG_W  = 8,
   parameter int unsigned     TAP_HI = 7,
   parameter int unsigned     TAP_LO = 6,
   parameter logic [REG_W-1:0] SEED  = 8'h81
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [REG_W-1:0] word,
   output logic             sbit
);

   logic [REG_W-1:0] shreg_q;
   logic             fb;

   if (TAP_HI > REG_W) begin : g_bad_width
      $error("prbs_lfsr_gen: register narrower than the highest tap");
   end

   assign fb = shreg_q[TAP_HI-1] ^ shreg_q[TAP_LO-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= SEED;
      end else if (step) begin
         shreg_q <= {shreg_q[REG_W-2:0], fb};
      end
   end

   assign word = shreg_q;
   assign sbit = shreg_q[0];

endmodule

// File: rtl/prbs_event_counter.sv
module prbs_event_counter #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] value
);

   logic [W-1:0] value_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (rst) begin
            value_q <= '0;
         end else if (inc && (value_q != {W{1'b1}})) begin
            value_q <= value_q + W'(1);
         end
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst) begin
            value_q <= '0;
         end else if (inc) begin
            value_q <= value_q + W'(1);
         end
      end
   end

   assign value = value_q;

endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
   parameter int unsigned WIN_LEN = 64,
   parameter int unsigned WIN_ERR = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic shift,
   input  logic err_in,
   output logic trip
);

   localparam int unsigned CW = prbs_pkg::cnt_width(WIN_LEN);

   logic [WIN_LEN-1:0] flags_q;
   logic [CW-1:0]      count_q;
   logic [CW-1:0]      count_nx;

   if (WIN_LEN < 2) begin : g_bad_len
      $error("prbs_err_window: window must span at least two bits");
   end
   if ((WIN_ERR < 1) || (WIN_ERR > WIN_LEN)) begin : g_bad_thr
      $error("prbs_err_window: threshold must lie within the window");
   end

   always_comb begin
      count_nx = count_q + CW'(err_in) - CW'(flags_q[WIN_LEN-1]);
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         flags_q <= '0;
         count_q <= '0;
      end else if (shift) begin
         flags_q <= {flags_q[WIN_LEN-2:0], err_in};
         count_q <= count_nx;
      end
   end

   assign trip = shift && (count_nx >= CW'(WIN_ERR));

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
   parameter int unsigned TAP_HI   = 7,
   parameter int unsigned TAP_LO   = 6,
   parameter int unsigned LOCK_RUN = 16,
   parameter int unsigned WIN_LEN  = 64,
   parameter int unsigned WIN_ERR  = 8,
   parameter int unsigned CNT_W    = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_bit,
   output logic             locked,
   output logic             err_pulse,
   output logic [CNT_W-1:0] err_count,
   output logic [CNT_W-1:0] bit_count
);

   import prbs_pkg::*;

   localparam int unsigned ORDER  = TAP_HI;
   localparam int unsigned FILL_W = cnt_width(ORDER);
   localparam int unsigned RUN_W  = cnt_width(LOCK_RUN);

   sync_state_e       state_q;
   logic [ORDER-1:0]  hist_q;
   logic [FILL_W-1:0] fill_q;
   logic [RUN_W-1:0]  run_q;
   logic              err_q;
   logic              pred;
   logic              miss;
   logic              chk_en;
   logic              trip;

   if (LOCK_RUN < 1) begin : g_bad_run
      $error("prbs_rx_checker: lock run must be at least one");
   end

   assign pred   = hist_q[TAP_HI-1] ^ hist_q[TAP_LO-1];
   assign miss   = in_bit ^ pred;
   assign chk_en = (state_q == SYNC_LOCK) && in_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SYNC_FILL;
         hist_q  <= '0;
         fill_q  <= '0;
         run_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= chk_en && miss;
         if (in_valid) begin
            case (state_q)
               SYNC_FILL: begin
                  hist_q <= {hist_q[ORDER-2:0], in_bit};
                  if (fill_q == FILL_W'(ORDER - 1)) begin
                     state_q <= SYNC_TRAIN;
                     fill_q  <= '0;
                     run_q   <= '0;
                  end else begin
                     fill_q <= fill_q + FILL_W'(1);
                  end
               end
               SYNC_TRAIN: begin
                  hist_q <= {hist_q[ORDER-2:0], in_bit};
                  if (miss) begin
                     run_q <= '0;
                  end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                     state_q <= SYNC_LOCK;
                     run_q   <= '0;
                  end else begin
                     run_q <= run_q + RUN_W'(1);
                  end
               end
               SYNC_LOCK: begin
                  hist_q <= {hist_q[ORDER-2:0], pred};
                  if (trip) begin
                     state_q <= SYNC_FILL;
                     fill_q  <= '0;
                  end
               end
               default: begin
                  state_q <= SYNC_FILL;
                  fill_q  <= '0;
               end
            endcase
         end
      end
   end

   prbs_err_window #(
      .WIN_LEN (WIN_LEN),
      .WIN_ERR (WIN_ERR)
   ) u_window (
      .clk    (clk),
      .rst    (rst),
      .clr    (state_q != SYNC_LOCK),
      .shift  (chk_en),
      .err_in (miss),
      .trip   (trip)
   );

   prbs_event_counter #(
      .W        (CNT_W),
      .SATURATE (SATURATE)
   ) u_err_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (chk_en && miss),
      .value (err_count)
   );

   prbs_event_counter #(
      .W        (CNT_W),
      .SATURATE (SATURATE)
   ) u_bit_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (chk_en),
      .value (bit_count)
   );

   assign locked    = (state_q == SYNC_LOCK);
   assign err_pulse = err_q;

endmodule

// File: rtl/prbs7_link.sv
module prbs7_link #(
   parameter int unsigned      REG_W    = 8,
   parameter int unsigned      TAP_HI   = 7,
   parameter int unsigned      TAP_LO   = 6,
   parameter logic [REG_W-1:0] SEED     = 8'h81,
   parameter int unsigned      LOCK_RUN = 16,
   parameter int unsigned      WIN_LEN  = 64,
   parameter int unsigned      WIN_ERR  = 8,
   parameter int unsigned      CNT_W    = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gen_en,
   output logic [REG_W-1:0] gen_word,
   output logic             gen_bit,
   input  logic             rx_valid,
   input  logic             rx_bit,
   output logic             rx_locked,
   output logic             rx_err,
   output logic [CNT_W-1:0] rx_err_count,
   output logic [CNT_W-1:0] rx_bit_count
);

   if (!(TAP_HI > TAP_LO && TAP_LO >= 1)) begin : g_bad_taps
      $error("prbs7_link: taps must satisfy TAP_HI > TAP_LO >= 1");
   end
   if (REG_W < TAP_HI) begin : g_bad_reg
      $error("prbs7_link: register must hold every tap");
   end
   if (SEED[TAP_HI-1:0] == '0) begin : g_bad_seed
      $error("prbs7_link: seed would start in the all-zero lock-up state");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("prbs7_link: counters need at least two bits");
   end

   prbs_lfsr_gen #(
      .REG_W  (REG_W),
      .TAP_HI (TAP_HI),
      .TAP_LO (TAP_LO),
      .SEED   (SEED)
   ) u_gen (
      .clk  (clk),
      .rst  (rst),
      .step (gen_en),
      .word (gen_word),
      .sbit (gen_bit)
   );

   prbs_rx_checker #(
      .TAP_HI   (TAP_HI),
      .TAP_LO   (TAP_LO),
      .LOCK_RUN (LOCK_RUN),
      .WIN_LEN  (WIN_LEN),
      .WIN_ERR  (WIN_ERR),
      .CNT_W    (CNT_W),
      .SATURATE (1'b1)
   ) u_chk (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (rx_valid),
      .in_bit    (rx_bit),
      .locked    (rx_locked),
      .err_pulse (rx_err),
      .err_count (rx_err_count),
      .bit_count (rx_bit_count)
   );

endmodule

// File: rtl/prbs7_link_sva.sv
module prbs7_link_sva #(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned TAP_HI = 7,
   parameter int unsigned TAP_LO = 6,
   parameter int unsigned CNT_W  = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             gen_en,
   input logic [REG_W-1:0] gen_word,
   input logic             rx_valid,
   input logic             rx_locked,
   input logic             rx_err,
   input logic [CNT_W-1:0] rx_err_count,
   input logic [CNT_W-1:0] rx_bit_count
);

   a_r2_shift: assert property (@(posedge clk) disable iff (rst)
      gen_en |=> (gen_word[REG_W-1:1] == $past(gen_word[REG_W-2:0])));

   a_r2_feedback: assert property (@(posedge clk) disable iff (rst)
      gen_en |=> (gen_word[0] == ($past(gen_word[TAP_HI-1]) ^ $past(gen_word[TAP_LO-1]))));

   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !gen_en |=> $stable(gen_word));

   a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst)
      gen_word[TAP_HI-1:0] != '0);

   a_r6_err_needs_lock: assert property (@(posedge clk) disable iff (rst)
      rx_err |-> ($past(rx_locked) && $past(rx_valid)));

   a_r6_err_counted: assert property (@(posedge clk) disable iff (rst)
      (rx_err && ($past(rx_err_count) != {CNT_W{1'b1}}))
         |-> (rx_err_count == $past(rx_err_count) + CNT_W'(1)));

   a_r7_bits_only_locked: assert property (@(posedge clk) disable iff (rst)
      !rx_locked |=> $stable(rx_bit_count));

   a_r8_err_sat: assert property (@(posedge clk) disable iff (rst)
      (rx_err_count == {CNT_W{1'b1}}) |=> (rx_err_count == {CNT_W{1'b1}}));

   a_r10_idle: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |=> ($stable(rx_err_count) && $stable(rx_bit_count)
                     && $stable(rx_locked) && !rx_err));

endmodule

bind prbs7_link prbs7_link_sva #(
   .REG_W  (REG_W),
   .TAP_HI (TAP_HI),
   .TAP_LO (TAP_LO),
   .CNT_W  (CNT_W)
) u_sva (
   .clk          (clk),
   .rst          (rst),
   .gen_en       (gen_en),
   .gen_word     (gen_word),
   .rx_valid     (rx_valid),
   .rx_locked    (rx_locked),
   .rx_err       (rx_err),
   .rx_err_count (rx_err_count),
   .rx_bit_count (rx_bit_count)
);

// File: tb/sim_prbs7_link.sv
`timescale 1ns/1ps
module sim_prbs7_link;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 8;
   localparam int CMAX       = (1 << CW) - 1;
   localparam logic [7:0] SEED_V = 8'h81;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          gen_en = 1'b0;
   logic          vld = 1'b0;
   logic          flip = 1'b0;
   logic [7:0]    gen_word;
   logic          gen_bit;
   logic          rx_bit;
   logic          rx_locked;
   logic          rx_err;
   logic [CW-1:0] rx_err_count;
   logic [CW-1:0] rx_bit_count;

   int n_checks = 0;
   int n_fail   = 0;

   // reference model state
   bit gq[$];
   bit hq[$];
   bit wq[$];
   int mmode, mfill, mrun, merrs, mbits;
   bit exp_err;

   assign rx_bit = gen_bit ^ flip;

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs7_link #(.CNT_W(CW)) u0 (
      .clk          (clk),
      .rst          (rst),
      .gen_en       (gen_en),
      .gen_word     (gen_word),
      .gen_bit      (gen_bit),
      .rx_valid     (vld),
      .rx_bit       (rx_bit),
      .rx_locked    (rx_locked),
      .rx_err       (rx_err),
      .rx_err_count (rx_err_count),
      .rx_bit_count (rx_bit_count)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_word();
      logic [7:0] w;
      for (int k = 0; k < 8; k++) w[k] = gq[gq.size()-1-k];
      return w;
   endfunction

   task automatic model_reset();
      gq.delete(); hq.delete(); wq.delete();
      for (int k = 7; k >= 0; k--) gq.push_back(SEED_V[k]);
      mmode = 0; mfill = 0; mrun = 0; merrs = 0; mbits = 0; exp_err = 0;
   endtask

   task automatic compare();
      chk(gen_word == exp_word(), "R2 word", gen_word, exp_word());
      chk(gen_bit == gq[gq.size()-1], "R1 serial bit", gen_bit, gq[gq.size()-1]);
      chk(rx_locked == (mmode == 2), "R5 lock", rx_locked, (mmode == 2));
      chk(rx_err == exp_err, "R6 err pulse", rx_err, exp_err);
      chk(rx_err_count == CW'(merrs), "R6 err count", rx_err_count, merrs);
      chk(rx_bit_count == CW'(mbits), "R7 bit count", rx_bit_count, mbits);
   endtask

   task automatic tick();
      bit rxb, p, bad;
      int cnt;
      rxb = gq[gq.size()-1] ^ flip;
      exp_err = 0;
      if (vld) begin
         if (mmode == 0) begin
            hq.push_back(rxb);
            mfill++;
            if (mfill == 7) begin mmode = 1; mrun = 0; end
         end else if (mmode == 1) begin
            p = hq[hq.size()-7] ^ hq[hq.size()-6];
            hq.push_back(rxb);
            if (p != rxb) mrun = 0;
            else begin
               mrun++;
               if (mrun == 16) mmode = 2;
            end
         end else begin
            p = hq[hq.size()-7] ^ hq[hq.size()-6];
            bad = (p != rxb);
            hq.push_back(p);
            if (mbits < CMAX) mbits++;
            if (bad) begin
               exp_err = 1;
               if (merrs < CMAX) merrs++;
            end
            wq.push_back(bad);
            if (wq.size() > 64) void'(wq.pop_front());
            cnt = 0;
            foreach (wq[i]) cnt += wq[i];
            if (cnt >= 8) begin
               mmode = 0; mfill = 0; wq.delete();
            end
         end
         if (hq.size() > 16) void'(hq.pop_front());
      end
      if (gen_en) begin
         gq.push_back(gq[gq.size()-7] ^ gq[gq.size()-6]);
         if (gq.size() > 16) void'(gq.pop_front());
      end
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic do_reset();
      rst = 1; gen_en = 0; vld = 0; flip = 0;
      repeat (3) @(posedge clk);
      #1;
      rst = 0;
      model_reset();
      chk(gen_word == SEED_V, "R1 reset word", gen_word, SEED_V);
      chk(gen_bit == SEED_V[0], "R1 reset serial bit", gen_bit, SEED_V[0]);
      chk(!rx_locked && !rx_err, "R1 reset checker idle", {rx_locked, rx_err}, 0);
      chk(rx_err_count == 0 && rx_bit_count == 0, "R1 reset counters",
          {rx_err_count, rx_bit_count}, 0);
   endtask

   task automatic flip_one();
      flip = 1; tick(); flip = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin
      int seen[int];
      int lock_at, prev, lat;
      bit repeated;
      logic [7:0] held;

      do_reset();

      // full period, lock latency and bit counting
      gen_en = 1; vld = 1;
      lock_at = 0; repeated = 0;
      seen[int'(gen_word)] = 1;
      for (int i = 1; i <= 127; i++) begin
         tick();
         if (rx_locked && lock_at == 0) lock_at = i;
         if (i < 127) begin
            if (seen.exists(int'(gen_word))) repeated = 1;
            seen[int'(gen_word)] = 1;
         end
      end
      chk(!repeated, "R4 no repeat within period", repeated, 0);
      chk(gen_word == SEED_V, "R4 back to seed after 127", gen_word, SEED_V);
      chk(lock_at == 23, "R5 lock after 23 bits", lock_at, 23);
      chk(rx_bit_count == 104, "R7 bits counted while locked", rx_bit_count, 104);

      // idle cycles: generator holds, checker ignores line
      gen_en = 0; vld = 0;
      held = gen_word;
      prev = rx_err_count;
      for (int i = 0; i < 10; i++) begin
         flip = i[0];
         tick();
      end
      flip = 0;
      chk(gen_word == held, "R3 word holds", gen_word, held);
      chk(rx_locked && rx_err_count == CW'(prev) && rx_bit_count == 104,
          "R10 idle leaves checker", {rx_locked, rx_err_count}, {1'b1, CW'(prev)});

      // isolated single errors
      gen_en = 1; vld = 1;
      for (int e = 0; e < 4; e++) begin
         repeat (70) tick();
         prev = rx_err_count;
         flip_one();
         chk(rx_err == 1 && rx_err_count == CW'(prev + 1), "R6 single error counted once",
             rx_err_count, prev + 1);
         tick();
         chk(rx_err == 0 && rx_err_count == CW'(prev + 1), "R6 pulse one cycle, no echo",
             {rx_err, rx_err_count}, prev + 1);
      end
      chk(rx_bit_count == CW'(CMAX), "R8 bit count saturates", rx_bit_count, CMAX);

      // seven errors in a window keep lock
      repeat (70) tick();
      for (int e = 0; e < 7; e++) begin
         flip_one();
         repeat (4) tick();
      end
      chk(rx_locked == 1, "R9 seven errors keep lock", rx_locked, 1);

      // eight errors in a window drop lock
      repeat (70) tick();
      for (int e = 0; e < 8; e++) begin
         if (e != 0) repeat (4) tick();
         flip_one();
      end
      chk(rx_locked == 0, "R9 eighth error drops lock", rx_locked, 0);

      // relock with a wrong bit during training
      repeat (12) tick();
      flip_one();
      lat = 13;
      while (!rx_locked && lat < 300) begin
         tick();
         lat++;
      end
      chk(rx_locked == 1 && lat > 23, "R5 training miss restarts run", lat, 24);

      // error counter saturation
      while (rx_err_count != CW'(CMAX) && rx_locked) begin
         flip_one();
         repeat (9) tick();
      end
      chk(rx_err_count == CW'(CMAX), "R8 err count reaches full", rx_err_count, CMAX);
      flip_one();
      chk(rx_err == 1 && rx_err_count == CW'(CMAX), "R8 err count holds at full",
          {rx_err, rx_err_count}, {1'b1, CW'(CMAX)});
      repeat (5) tick();

      // reset mid-run
      do_reset();
      gen_en = 1; vld = 1;
      repeat (30) tick();
      chk(rx_locked == 1, "R5 lock after mid-run reset", rx_locked, 1);

      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

endmodule